// File: doc/BRIEF.md
# Level-Match GPIO Controller

This block is a register-mapped general-purpose I/O controller for up to 32 pins. For each pin, software picks either GPIO use or an alternate peripheral function. It sets the pin's direction and writes the values that output pins drive. It reads back the synchronized pin levels through the data register. Each pin also has a latched interrupt flag. The flag is set whenever the pin's synchronized level equals a per-pin polarity bit that software programs, and it stays set until software clears it. An enable mask chooses which flags feed a single registered non-maskable interrupt line.

Register access uses a request channel and a response channel. The request channel is `req_valid`/`req_ready`. `req_ready` is always high, so the block never applies back-pressure, and a request is taken on every clock edge where `req_valid` is high. A write request takes effect at that edge. A read request returns `rsp_valid` high for exactly one cycle after that edge, with `rsp_rdata` holding the register contents from just before the edge. The response channel has no ready signal, so the requester must accept every response. The alternate peripherals connect through the plain `alt_*` ports. Pad electronics are outside the block.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: `req_ready` is always 1. A read request gets `rsp_valid`=1 in the following cycle with the register value. Reads of any address other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 return 0.
- R2: The register map is as follows. 0x00 is function select. 0x04 is direction. 0x08 is data. 0x0C is match level. 0x10 is interrupt status. 0x14 is NMI enable. Function select, direction, match level and NMI enable read back the last value written.
- R3: When function-select bit i is 1, `pin_out[i]`/`pin_oe[i]` follow `alt_out[i]`/`alt_oe[i]`. `alt_in` carries the synchronized pin levels.
- R4: When function-select bit i is 0, `pin_oe[i]` equals direction bit i (1 = output) and `pin_out[i]` equals the last value written to data bit i.
- R5: Reading the data register returns the pin levels after a two-flop synchronizer, not the values written to it.
- R6: Status bit i becomes 1 on the third clock edge after `pin_in[i]` changes to equal match-level bit i.
- R7: A status bit, once set, holds even after the match ends. Writing 0 to a status bit clears it. Writing 1 leaves it unchanged.
- R8: If a status bit is cleared in the same cycle that its match holds, it stays 1.
- R9: `nmi_out` is the OR over all bits of (status AND NMI enable), delayed by one register stage.
- R10: After reset, all registers are 0. Every pin is then a GPIO input (`pin_oe`=0) and `nmi_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | N | Pad input levels (asynchronous) |
| pin_out | output | N | Pad output values |
| pin_oe | output | N | Pad output enables |
| alt_out | input | N | Alternate function output values |
| alt_oe | input | N | Alternate function output enables |
| alt_in | output | N | Synchronized pin levels to alternate functions |
| nmi_out | output | 1 | Registered non-maskable interrupt |

## Verification
A wrong select or direction register shows at `pin_oe`/`pin_out` in the same cycle as the write. A wrong synchronizer depth moves the data readback and shifts the `nmi_out` rise away from the fourth edge after a pin change, and the bench checks that rise cycle by cycle. A status flag that wrongly drops, or that a written 1 wrongly clears, shows at the next status read and at `nmi_out` one cycle later. A lost set-over-clear priority shows as a zero status read while the pins still match.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_FUNC  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR   = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_DATA  = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_LEVEL = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_NMIEN = 5'h14;

  typedef enum logic [2:0] {
    SEL_FUNC, SEL_DIR, SEL_DATA, SEL_LEVEL, SEL_STAT, SEL_NMIEN, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFF_FUNC:  s = SEL_FUNC;
      OFF_DIR:   s = SEL_DIR;
      OFF_DATA:  s = SEL_DATA;
      OFF_LEVEL: s = SEL_LEVEL;
      OFF_STAT:  s = SEL_STAT;
      OFF_NMIEN: s = SEL_NMIEN;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];

  // warm-up counter so the latency check only looks at cycles after reset
  logic [7:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q < 8'(STAGES)) warm_q <= warm_q + 8'd1;
  end

  assert_sync_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 8'(STAGES)) |-> (dout == $past(din, STAGES)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] func_sel,
  input  logic [N-1:0] dir,
  input  logic [N-1:0] drv_val,
  input  logic [N-1:0] alt_out,
  input  logic [N-1:0] alt_oe,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign pin_out[i] = func_sel[i] ? alt_out[i] : drv_val[i];
    assign pin_oe[i]  = func_sel[i] ? alt_oe[i]  : dir[i];
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_sync,
  input  logic [N-1:0] level,
  input  logic [N-1:0] nmi_en,
  input  logic         clr_we,
  input  logic [N-1:0] clr_wdata,
  output logic [N-1:0] status,
  output logic         nmi
);
  logic [N-1:0] match;
  logic [N-1:0] keep_mask;
  logic [N-1:0] status_q;
  logic         nmi_q;

  assign match     = ~(pin_sync ^ level);
  assign keep_mask = clr_we ? clr_wdata : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      nmi_q    <= 1'b0;
    end else begin
      status_q <= (status_q & keep_mask) | match;
      nmi_q    <= |(status_q & nmi_en);
    end
  end

  assign status = status_q;
  assign nmi    = nmi_q;

  assert_set_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(match)) == $past(match)));

  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((status_q & ~$past(clr_wdata) & ~$past(match)) == '0));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((status_q & $past(match & ~clr_wdata)) == $past(match & ~clr_wdata)));
endmodule

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl
  import gpio_lvl_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [REG_W-1:0]  rsp_rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  input  logic [N-1:0]      alt_out,
  input  logic [N-1:0]      alt_oe,
  output logic [N-1:0]      alt_in,
  output logic              nmi_out
);
  logic [N-1:0] func_q, dir_q, drv_q, level_q, nmien_q;
  logic [N-1:0] pin_sync, stat_w;
  logic [N-1:0] wdata_n;
  reg_sel_e     sel;
  logic         wr_en, rd_en, stat_we;
  logic [REG_W-1:0] rd_mux;
  logic         rsp_valid_q;
  logic [REG_W-1:0] rsp_rdata_q;

  assign req_ready = 1'b1;
  assign sel       = decode_addr(req_addr);
  assign wr_en     = req_valid & req_write;
  assign rd_en     = req_valid & ~req_write;
  assign wdata_n   = req_wdata[N-1:0];
  assign stat_we   = wr_en & (sel == SEL_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q  <= '0;
      dir_q   <= '0;
      drv_q   <= '0;
      level_q <= '0;
      nmien_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_FUNC:  func_q  <= wdata_n;
        SEL_DIR:   dir_q   <= wdata_n;
        SEL_DATA:  drv_q   <= wdata_n;
        SEL_LEVEL: level_q <= wdata_n;
        SEL_NMIEN: nmien_q <= wdata_n;
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_FUNC:  rd_mux[N-1:0] = func_q;
      SEL_DIR:   rd_mux[N-1:0] = dir_q;
      SEL_DATA:  rd_mux[N-1:0] = pin_sync;
      SEL_LEVEL: rd_mux[N-1:0] = level_q;
      SEL_STAT:  rd_mux[N-1:0] = stat_w;
      SEL_NMIEN: rd_mux[N-1:0] = nmien_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_en;
      rsp_rdata_q <= rd_en ? rd_mux : '0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  gpio_in_sync #(.W(N), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_sync)
  );

  assign alt_in = pin_sync;

  gpio_pin_mux #(.N(N)) u_mux (
    .func_sel(func_q), .dir(dir_q), .drv_val(drv_q),
    .alt_out(alt_out), .alt_oe(alt_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  gpio_irq_unit #(.N(N)) u_irq (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .level(level_q),
    .nmi_en(nmien_q), .clr_we(stat_we), .clr_wdata(wdata_n),
    .status(stat_w), .nmi(nmi_out)
  );

  assert_read_response_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  assert_gpio_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (func_q == '0 && dir_q == '0) |-> (pin_oe == '0));

  assert_nmi_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (nmi_out == ($past(stat_w & nmien_q) != '0)));
endmodule

// File: tb/gpio_lvl_ctrl_bench.sv
module gpio_lvl_ctrl_bench;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [4:0]    req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe, alt_in;
  logic [N-1:0]  alt_out = '0;
  logic [N-1:0]  alt_oe = '0;
  logic          nmi_out;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_lvl_ctrl #(.N(N)) u_gpio_lvl_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .alt_out(alt_out), .alt_oe(alt_oe),
    .alt_in(alt_in), .nmi_out(nmi_out)
  );

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    v = rsp_valid; d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic read_expect(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic v;
    bus_read(a, d, v);
    check_eq({req, " rsp_valid"}, {31'd0, v}, 32'd1);
    check_eq(req, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check_eq("R10 pin_oe", pin_oe, '0);
    check_eq("R10 nmi_out", {31'd0, nmi_out}, 32'd0);
    check_eq("R1 req_ready", {31'd0, req_ready}, 32'd1);
    read_expect("R10 func", 5'h00, 32'h0);
    read_expect("R10 dir", 5'h04, 32'h0);
    read_expect("R10 level", 5'h0C, 32'h0);
    read_expect("R10 nmien", 5'h14, 32'h0);
  endtask

  task automatic t_reg_rw();
    bus_write(5'h00, 32'hA5A5_0F0F);
    bus_write(5'h04, 32'h1234_8765);
    bus_write(5'h0C, 32'hDEAD_BEEF);
    bus_write(5'h14, 32'h0000_0000);
    read_expect("R2 func", 5'h00, 32'hA5A5_0F0F);
    read_expect("R2 dir", 5'h04, 32'h1234_8765);
    read_expect("R2 level", 5'h0C, 32'hDEAD_BEEF);
    bus_write(5'h14, 32'h8000_0001);
    read_expect("R2 nmien", 5'h14, 32'h8000_0001);
    bus_write(5'h00, 32'h0);
    bus_write(5'h04, 32'h0);
    bus_write(5'h0C, 32'h0);
    bus_write(5'h14, 32'h0);
  endtask

  task automatic t_unused();
    read_expect("R1 unused 0x18", 5'h18, 32'h0);
    read_expect("R1 unused 0x1C", 5'h1C, 32'h0);
    read_expect("R1 unaligned 0x02", 5'h02, 32'h0);
  endtask

  task automatic t_set_wins();
    // pins 0, level 0: every bit matches continuously
    pin_in = '0;
    idle(4);
    bus_write(5'h10, 32'h0);
    read_expect("R8 status after clear during match", 5'h10, 32'hFFFF_FFFF);
  endtask

  task automatic t_sticky_nmi();
    pin_in = '0;
    bus_write(5'h0C, 32'hFFFF_FFFF);
    idle(3);
    bus_write(5'h10, 32'h0);
    read_expect("R7 status cleared", 5'h10, 32'h0);
    bus_write(5'h14, 32'h0000_0020);
    idle(2);
    check_eq("R9 nmi idle", {31'd0, nmi_out}, 32'd0);
    @(negedge clk);
    pin_in = 32'h0000_0020;
    @(posedge clk); @(posedge clk); @(posedge clk); #2;
    check_eq("R9 nmi before latency", {31'd0, nmi_out}, 32'd0);
    @(posedge clk); #2;
    check_eq("R6 R9 nmi after 4 edges", {31'd0, nmi_out}, 32'd1);
    @(negedge clk);
    pin_in = '0;
    idle(4);
    read_expect("R7 sticky after match ends", 5'h10, 32'h0000_0020);
    bus_write(5'h10, 32'hFFFF_FFFF);
    read_expect("R7 write one keeps", 5'h10, 32'h0000_0020);
    check_eq("R9 nmi held", {31'd0, nmi_out}, 32'd1);
    bus_write(5'h10, 32'hFFFF_FFDF);
    check_eq("R9 nmi one cycle after clear", {31'd0, nmi_out}, 32'd1);
    @(negedge clk);
    check_eq("R9 nmi dropped", {31'd0, nmi_out}, 32'd0);
    read_expect("R7 write zero clears", 5'h10, 32'h0);
    bus_write(5'h14, 32'h0);
  endtask

  task automatic t_data_readback();
    pin_in = 32'h1234_5678;
    bus_write(5'h08, 32'hFFFF_0000);
    idle(3);
    read_expect("R5 data reads pins", 5'h08, 32'h1234_5678);
    check_eq("R3 alt_in", alt_in, 32'h1234_5678);
    check_eq("R4 inputs not driven", pin_oe, '0);
    pin_in = 32'hCAFE_0001;
    idle(3);
    read_expect("R5 data follows pins", 5'h08, 32'hCAFE_0001);
  endtask

  task automatic t_mux();
    alt_out = 32'h4; alt_oe = 32'h4;
    bus_write(5'h08, 32'h8);
    bus_write(5'h04, 32'hC);
    bus_write(5'h00, 32'h4);
    check_eq("R3 R4 pin_oe", pin_oe, 32'hC);
    check_eq("R3 R4 pin_out", pin_out & 32'h1C, 32'hC);
    @(negedge clk);
    alt_oe = '0; alt_out = '0;
    #1;
    check_eq("R3 alt_oe controls", pin_oe, 32'h8);
    check_eq("R3 alt_out controls", pin_out & 32'h1C, 32'h8);
    bus_write(5'h00, 32'h0);
    check_eq("R4 gpio oe", pin_oe, 32'hC);
    check_eq("R4 gpio out", pin_out & 32'h1C, 32'h8);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_reg_rw();
    t_unused();
    t_set_wins();
    t_sticky_nmi();
    t_data_readback();
    t_mux();
    idle(2);
    finish_run();
  end
endmodule